// File: doc/BRIEF.md
# Synchronous host bus register slave

This block sits on a synchronous processor bus and gives the host access to a small bank of registers. Every host input is sampled on the rising edge of the bus clock, which runs at about 66 MHz in the target system. A register access starts with a one-cycle start strobe, which is active high and arrives together with an active-low chip select. The start strobe latches the address. In the next cycle an active-low write strobe commits the write data, or an active-low output enable asks for read data. The data bus is split into an input, an output and an output-enable, so that the tri-state pad can live at the chip edge. The output enable is a combinational function of chip select and output enable alone.

Two DMA channels run beside the register path and bypass address decoding. The write channel raises a request while its receive FIFO has room. Each cycle in which its active-low acknowledge is low pushes one bus word into that FIFO. The read channel raises a request while its transmit FIFO holds data. Each acknowledge places the FIFO head on the bus and pops it. After a request is acknowledged it drops for at least one cycle.

The transaction state machine has two states. TX_IDLE waits for a start with chip select. TX_ADDR holds the latched address for one cycle and decodes the strobes as a write, a read, nothing, or a conflict. Its transitions are: TX_IDLE to TX_ADDR on start; TX_ADDR to TX_ADDR on a new start; TX_ADDR to TX_IDLE otherwise. Each DMA channel has three states. DC_IDLE moves to DC_REQ when the FIFO is ready. DC_REQ holds the request until the acknowledge is sampled low, then moves to DC_GAP. DC_GAP always returns to DC_IDLE.

Top module: `hostbus_reg_slave`

## Requirements
- R1: While reset is held, both DMA requests, the protocol error flag, the data output enable and the receive valid flag are low, and after reset every register reads zero.
- R2: A start strobe with chip select low latches the address. A write strobe (write enable low, output enable high, chip select low) in the next cycle stores the input data in that register.
- R3: The data output enable is high exactly while chip select and output enable are both low. During the cycle after a start, with output enable low and write enable high, the output carries the addressed register.
- R4: A write or output-enable strobe with no start strobe in the previous cycle performs no access. The register keeps its value and the output reads zero.
- R5: If write enable and output enable are both low in the cycle after a start, no register is written and the output reads zero in that cycle. The protocol error output is high for the one following cycle.
- R6: Registers exist at addresses 0 to NREGS-1 (0 to 7 by default). A read of any other address returns zero, and a write to it changes nothing.
- R7: The DMA write request stays high until its acknowledge is sampled low. It is then low for at least the next cycle.
- R8: Each cycle with the DMA write request high and its acknowledge low pushes the input data into the receive FIFO. The words leave the receive side in the order they arrived.
- R9: The DMA read request is high while the transmit FIFO holds data. An acknowledge with chip select and output enable low drives the oldest word on the output and removes it, and the request then drops for at least one cycle.
- R10: No DMA write request is raised while the receive FIFO is full, and no DMA read request while the transmit FIFO is empty. The transmit full flag is high at FIFO_DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_start | input | 1 | One-cycle transaction start strobe, active high |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_oe_n | input | 1 | Output enable (read strobe), active low |
| bus_addr | input | AW | Register address, latched by the start strobe |
| bus_din | input | DW | Data from the bus |
| bus_dout | output | DW | Data to the bus |
| bus_dout_en | output | 1 | Enable for the tri-state driver at the pad |
| proto_err | output | 1 | One-cycle pulse after a conflicting strobe pair |
| dma_wr_req | output | 1 | DMA write request |
| dma_wr_ack_n | input | 1 | DMA write acknowledge, active low |
| dma_rd_req | output | 1 | DMA read request |
| dma_rd_ack_n | input | 1 | DMA read acknowledge, active low |
| rx_pop | input | 1 | Removes the head word of the receive FIFO |
| rx_data | output | DW | Head word of the receive FIFO |
| rx_valid | output | 1 | Receive FIFO is not empty |
| tx_push | input | 1 | Writes a word into the transmit FIFO |
| tx_data | input | DW | Word for the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO is full |

## Verification
The hardest conditions to reach are the back-pressure points of the DMA channels. No write request must appear while the receive FIFO is full, and no read request while the transmit FIFO is empty. The stimulus reaches them by acknowledging write requests until the receive FIFO is full and leaving it unpopped for several cycles, and by draining a short burst of transmit words until none remain. A behavioural model made of queues and a register array predicts the output enable, the output data, the error pulse and the FIFO heads on every clock. Directed sequences create the conflicting strobes, the strobes without a start and the unmapped addresses.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic {
        TX_IDLE,
        TX_ADDR
    } txn_state_e;

    typedef enum logic [1:0] {
        DC_IDLE,
        DC_REQ,
        DC_GAP
    } dma_state_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_WRITE,
        ACC_READ,
        ACC_CONFLICT
    } acc_kind_e;

endpackage

// File: rtl/hb_txn_fsm.sv
module hb_txn_fsm
    import hb_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          start,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_q,
    output logic          wr_en,
    output logic          rd_sel,
    output logic          proto_err
);

    txn_state_e state_q, state_d;
    acc_kind_e  kind;
    logic       begin_txn;

    assign begin_txn = start && !cs_n;

    always_comb begin
        kind = ACC_NONE;
        if (!cs_n) begin
            unique case ({we_n, oe_n})
                2'b00:   kind = ACC_CONFLICT;
                2'b01:   kind = ACC_WRITE;
                2'b10:   kind = ACC_READ;
                default: kind = ACC_NONE;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (begin_txn) state_d = TX_ADDR;
            TX_ADDR: state_d = begin_txn ? TX_ADDR : TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= TX_IDLE;
            addr_q    <= '0;
            proto_err <= 1'b0;
        end else begin
            state_q   <= state_d;
            if (begin_txn) addr_q <= addr_in;
            proto_err <= (state_q == TX_ADDR) && (kind == ACC_CONFLICT);
        end
    end

    always_comb begin
        wr_en  = 1'b0;
        rd_sel = 1'b0;
        unique case (state_q)
            TX_IDLE: ;
            TX_ADDR: begin
                wr_en  = (kind == ACC_WRITE);
                rd_sel = (kind == ACC_READ);
            end
            default: ;
        endcase
    end

    AST_STROBE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_sel) |-> $past(start && !cs_n)); // R4

endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
    parameter int AW    = 6,
    parameter int DW    = 16,
    parameter int NREGS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int LAST = NREGS - 1;

    logic [DW-1:0] regs [NREGS];
    logic          mapped;

    assign mapped = (32'(addr) <= LAST);

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (32'(addr) == g)) begin
                regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (mapped && (32'(addr) == i)) rdata = regs[i];
        end
    end

endmodule

// File: rtl/hb_fifo.sv
module hb_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (32'(count) == DEPTH);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (32'(wp) == DEPTH - 1) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (32'(rp) == DEPTH - 1) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R10

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9

endmodule

// File: rtl/hb_dma_chan.sv
module hb_dma_chan
    import hb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic ack_n,
    output logic req,
    output logic xfer
);

    dma_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DC_IDLE: if (ready) state_d = DC_REQ;
            DC_REQ:  if (!ack_n) state_d = DC_GAP;
            DC_GAP:  state_d = DC_IDLE;
            default: state_d = DC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req  = 1'b0;
        xfer = 1'b0;
        unique case (state_q)
            DC_IDLE: ;
            DC_REQ: begin
                req  = 1'b1;
                xfer = !ack_n && ready;
            end
            DC_GAP:  ;
            default: ;
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack_n) |=> req); // R7

    AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack_n) |=> !req); // R7

endmodule

// File: rtl/hostbus_reg_slave.sv
module hostbus_reg_slave #(
    parameter int AW         = 6,
    parameter int DW         = 16,
    parameter int NREGS      = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs_n,
    input  logic          bus_start,
    input  logic          bus_we_n,
    input  logic          bus_oe_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en,
    output logic          proto_err,
    output logic          dma_wr_req,
    input  logic          dma_wr_ack_n,
    output logic          dma_rd_req,
    input  logic          dma_rd_ack_n,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_data,
    output logic          tx_full
);

    logic [AW-1:0] addr_q;
    logic          wr_en, rd_sel;
    logic [DW-1:0] reg_rdata, tx_head;
    logic          rx_full, rx_empty, tx_empty;
    logic          wr_xfer, rd_xfer;

    hb_txn_fsm #(.AW(AW)) txn_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (bus_cs_n),
        .start     (bus_start),
        .we_n      (bus_we_n),
        .oe_n      (bus_oe_n),
        .addr_in   (bus_addr),
        .addr_q    (addr_q),
        .wr_en     (wr_en),
        .rd_sel    (rd_sel),
        .proto_err (proto_err)
    );

    hb_regfile #(.AW(AW), .DW(DW), .NREGS(NREGS)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr_q),
        .wdata (bus_din),
        .rdata (reg_rdata)
    );

    hb_dma_chan wr_chan_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (!rx_full),
        .ack_n (dma_wr_ack_n),
        .req   (dma_wr_req),
        .xfer  (wr_xfer)
    );

    hb_dma_chan rd_chan_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (!tx_empty),
        .ack_n (dma_rd_ack_n),
        .req   (dma_rd_req),
        .xfer  (rd_xfer)
    );

    hb_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_xfer),
        .wdata (bus_din),
        .pop   (rx_pop),
        .head  (rx_data),
        .full  (rx_full),
        .empty (rx_empty)
    );

    hb_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .wdata (tx_data),
        .pop   (rd_xfer),
        .head  (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    assign rx_valid    = !rx_empty;
    assign bus_dout_en = !bus_cs_n && !bus_oe_n;

    always_comb begin
        if (rd_xfer)     bus_dout = tx_head;
        else if (rd_sel) bus_dout = reg_rdata;
        else             bus_dout = '0;
    end

    AST_ERR_FOLLOWS_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(!bus_we_n && !bus_oe_n && !bus_cs_n)); // R5

endmodule

// File: tb/hostbus_reg_slave_tb.sv
module hostbus_reg_slave_tb_top;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NREGS = 8;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_cs_n, bus_start, bus_we_n, bus_oe_n;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_din, bus_dout, rx_data, tx_data;
    logic          bus_dout_en, proto_err, dma_wr_req, dma_wr_ack_n;
    logic          dma_rd_req, dma_rd_ack_n, rx_pop, rx_valid, tx_push, tx_full;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hostbus_reg_slave #(.AW(AW), .DW(DW), .NREGS(NREGS), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_start(bus_start),
        .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n), .bus_addr(bus_addr),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .proto_err(proto_err), .dma_wr_req(dma_wr_req), .dma_wr_ack_n(dma_wr_ack_n),
        .dma_rd_req(dma_rd_req), .dma_rd_ack_n(dma_rd_ack_n), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_valid(rx_valid), .tx_push(tx_push),
        .tx_data(tx_data), .tx_full(tx_full)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, compared on every clock
    logic [DW-1:0] m_regs [NREGS];
    logic [DW-1:0] m_rx [$];
    logic [DW-1:0] m_tx [$];
    bit            m_phase, m_err;
    int            m_addr;

    always @(negedge clk) begin
        #5;
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) m_regs[i] = '0;
            m_rx.delete();
            m_tx.delete();
            m_phase = 0;
            m_err = 0;
            m_addr = 0;
        end else begin
            logic [DW-1:0] exp_d;
            bit            err_n;
            chk(bus_dout_en == (!bus_cs_n && !bus_oe_n), "R3 output enable",
                32'(bus_dout_en), 32'(!bus_cs_n && !bus_oe_n));
            exp_d = '0;
            if (dma_rd_req && !dma_rd_ack_n && m_tx.size() > 0) exp_d = m_tx[0];
            else if (m_phase && !bus_cs_n && !bus_oe_n && bus_we_n && m_addr < NREGS)
                exp_d = m_regs[m_addr];
            if (bus_dout_en) chk(bus_dout == exp_d, "R3/R9 output data", 32'(bus_dout), 32'(exp_d));
            chk(proto_err == m_err, "R5 error pulse", 32'(proto_err), 32'(m_err));
            chk(rx_valid == (m_rx.size() != 0), "R8 rx valid", 32'(rx_valid), 32'(m_rx.size() != 0));
            if (rx_valid && m_rx.size() != 0)
                chk(rx_data == m_rx[0], "R8 rx order", 32'(rx_data), 32'(m_rx[0]));
            chk(tx_full == (m_tx.size() == DEPTH), "R10 tx full", 32'(tx_full), 32'(m_tx.size() == DEPTH));
            err_n = 0;
            if (m_phase && !bus_cs_n) begin
                if (!bus_we_n && !bus_oe_n) err_n = 1;
                else if (!bus_we_n && m_addr < NREGS) m_regs[m_addr] = bus_din;
            end
            m_err = err_n;
            m_phase = bus_start && !bus_cs_n;
            if (m_phase) m_addr = int'(bus_addr);
            if (rx_pop && m_rx.size() != 0) void'(m_rx.pop_front());
            if (dma_wr_req && !dma_wr_ack_n) m_rx.push_back(bus_din);
            if (dma_rd_req && !dma_rd_ack_n && m_tx.size() != 0) void'(m_tx.pop_front());
            if (tx_push && m_tx.size() < DEPTH) m_tx.push_back(tx_data);
        end
    end

    task automatic idle_bus();
        bus_cs_n = 1; bus_start = 0; bus_we_n = 1; bus_oe_n = 1;
        dma_wr_ack_n = 1; dma_rd_ack_n = 1; rx_pop = 0; tx_push = 0;
    endtask

    task automatic reg_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_start = 1; bus_cs_n = 0; bus_addr = AW'(a);
        @(negedge clk);
        bus_start = 0; bus_we_n = 0; bus_din = d;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic reg_read(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_start = 1; bus_cs_n = 0; bus_addr = AW'(a);
        @(negedge clk);
        bus_start = 0; bus_oe_n = 0;
        #2 d = bus_dout;
        @(negedge clk);
        idle_bus();
    endtask

    logic [DW-1:0] rd;
    logic [DW-1:0] rxv [DEPTH];

    initial begin
        idle_bus();
        bus_addr = '0; bus_din = '0; tx_data = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        #2;
        chk(!dma_wr_req && !dma_rd_req, "R1 requests low in reset", {dma_wr_req, dma_rd_req}, 0);
        chk(!proto_err && !bus_dout_en && !rx_valid, "R1 flags low in reset",
            {proto_err, bus_dout_en, rx_valid}, 0);
        @(negedge clk);
        rst_n = 1;
        reg_read(3, rd);
        chk(rd == 0, "R1 register zero after reset", rd, 0);

        reg_write(2, 16'hA5A5);
        reg_write(7, 16'h1234);
        reg_write(0, 16'hFFFF);
        reg_read(2, rd); chk(rd == 16'hA5A5, "R2 write/read reg2", rd, 16'hA5A5);
        reg_read(7, rd); chk(rd == 16'h1234, "R2 write/read reg7", rd, 16'h1234);
        reg_read(0, rd); chk(rd == 16'hFFFF, "R2 write/read reg0", rd, 16'hFFFF);

        reg_write(9, 16'hBEEF);
        reg_read(9, rd); chk(rd == 0, "R6 unmapped read 9", rd, 0);
        reg_read(8, rd); chk(rd == 0, "R6 unmapped read 8", rd, 0);
        reg_read(1, rd); chk(rd == 0, "R6 unmapped write left reg1", rd, 0);

        @(negedge clk);
        bus_cs_n = 0; bus_we_n = 0; bus_din = 16'hDEAD; bus_addr = 2;
        @(negedge clk);
        idle_bus();
        reg_read(2, rd); chk(rd == 16'hA5A5, "R4 write without start ignored", rd, 16'hA5A5);
        @(negedge clk);
        bus_cs_n = 0; bus_oe_n = 0;
        #2 chk(bus_dout_en && bus_dout == 0, "R4 read without start returns zero", bus_dout, 0);
        @(negedge clk);
        bus_oe_n = 1;
        #2 chk(!bus_dout_en, "R3 no enable with oe high", bus_dout_en, 0);
        @(negedge clk);
        bus_cs_n = 1; bus_oe_n = 0;
        #2 chk(!bus_dout_en, "R3 no enable with cs high", bus_dout_en, 0);
        @(negedge clk);
        idle_bus();

        @(negedge clk);
        bus_start = 1; bus_cs_n = 0; bus_addr = 7;
        @(negedge clk);
        bus_start = 0; bus_we_n = 0; bus_oe_n = 0; bus_din = 16'h0BAD;
        #2 chk(bus_dout == 0, "R5 conflict drives zero", bus_dout, 0);
        @(negedge clk);
        idle_bus();
        #2 chk(proto_err, "R5 error pulse after conflict", proto_err, 1);
        @(negedge clk);
        #2 chk(!proto_err, "R5 error pulse one cycle", proto_err, 0);
        reg_read(7, rd); chk(rd == 16'h1234, "R5 conflict no write", rd, 16'h1234);

        // DMA write channel
        repeat (3) begin
            @(negedge clk);
            #2 chk(dma_wr_req, "R7 request held without ack", dma_wr_req, 1);
        end
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk); #2;
            while (!dma_wr_req) begin @(negedge clk); #2; end
            rxv[k] = DW'(16'h5000 + k * 16'h0111);
            dma_wr_ack_n = 0; bus_din = rxv[k];
            @(negedge clk);
            dma_wr_ack_n = 1;
            #2 chk(!dma_wr_req, "R7 request drops after ack", dma_wr_req, 0);
        end
        repeat (5) begin
            @(negedge clk);
            #2 chk(!dma_wr_req, "R10 no write request when rx full", dma_wr_req, 0);
        end
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            #2 chk(rx_valid && rx_data == rxv[k], "R8 rx word order", rx_data, rxv[k]);
            rx_pop = 1;
            @(negedge clk);
            rx_pop = 0;
        end
        repeat (3) @(negedge clk);
        #2 chk(dma_wr_req && !rx_valid, "R7 request resumes when rx has room", dma_wr_req, 1);

        // DMA read channel
        repeat (2) begin
            @(negedge clk);
            #2 chk(!dma_rd_req, "R10 no read request when tx empty", dma_rd_req, 0);
        end
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            tx_push = 1; tx_data = DW'(16'hC000 + k);
        end
        @(negedge clk);
        tx_push = 0;
        #2 chk(tx_full, "R10 tx full at depth", tx_full, 1);
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk); #2;
            while (!dma_rd_req) begin @(negedge clk); #2; end
            bus_cs_n = 0; bus_oe_n = 0; dma_rd_ack_n = 0;
            #1 chk(bus_dout_en && bus_dout == DW'(16'hC000 + k), "R9 dma read word",
                   bus_dout, 16'hC000 + k);
            @(negedge clk);
            idle_bus();
            #2 chk(!dma_rd_req, "R9 read request drops after ack", dma_rd_req, 0);
        end
        repeat (5) begin
            @(negedge clk);
            #2 chk(!dma_rd_req, "R10 no read request after drain", dma_rd_req, 0);
        end

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule